// File: doc/BRIEF.md
# Bus watch timeout detector

This block guards the data phase of a local bus against a target that never answers. A data-phase strobe (`data_en`) opens each beat. While it is high and no ready has come back, an 8-bit wait counter advances. When the count reaches a programmable limit, the block enters a recovery state. Such a stall is usually caused by an address that falls in an unpopulated memory region.

In recovery the block raises a bus error flag and a forced-ready request, which the bus logic merges into its ready path. Each cycle in recovery completes one beat. Recovery lasts until the beat that carries the burst-last marker has been completed, so the processor is never left waiting. A limit of zero turns the watch off. Address decoding is done elsewhere.

Top module: `bus_watch_timer`

## Requirements
- R1: After reset, `bus_err` and `force_rdy` are both 0.
- R2: With a non-zero `limit` of L, a beat in which `data_en`=1 and `rdy_in`=0 on L consecutive rising edges raises `bus_err` and `force_rdy` to 1 right after the L-th such edge, and not earlier. L=1 and L=255 are both valid.
- R3: A rising edge with `data_en`=1 and `rdy_in`=1 clears the wait count, so the next beat gets a full window of L waiting edges.
- R4: A rising edge with `data_en`=0 clears the wait count.
- R5: In recovery, both outputs stay 1 on every cycle until a rising edge samples `burst_last`=1 with `data_en`=1. Both outputs are 0 after that edge.
- R6: In recovery, `rdy_in`=1 has no effect: both outputs stay 1 until the exit condition of R5 or R7.
- R7: A rising edge in recovery that samples `data_en`=0 ends recovery. Both outputs are 0 after that edge.
- R8: After recovery ends, a new stalled beat needs a full L waiting edges to time out again.
- R9: With `limit`=0, neither output ever rises, however long a beat waits.
- R10: `bus_err` and `force_rdy` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_en | input | 1 | Data phase active (active high) |
| rdy_in | input | 1 | Ready returned by the addressed target |
| burst_last | input | 1 | Current beat is the last of the burst |
| limit | input | 8 | Timeout in waiting cycles; 0 disables the watch |
| bus_err | output | 1 | Bus time-out error, held for each forced beat |
| force_rdy | output | 1 | Request to complete the current beat |

## Verification
The assertions assume that `limit` does not change while a beat is being watched. They also assume that `data_en` stays low for the two cycles after reset is released, while the internal reset release is still in flight. The checker's own wait counter would otherwise start counting edges that the design ignores. The directed tasks change `limit` only while `data_en` is low. Every stimulus ends with `data_en` low, and the bench waits several idle cycles after reset before starting.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [0:0] {
    WATCH   = 1'b0,
    RECOVER = 1'b1
  } bwt_state_e;
endpackage

// File: rtl/bwt_rst_sync.sv
module bwt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bwt_counter.sv
module bwt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  // Clearing wins over counting; the count saturates instead of wrapping.
  assign cnt_en = clr | (inc & (cnt_q != TOP));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/bwt_fsm.sv
module bwt_fsm
  import bwt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_en,
  input  logic         rdy_in,
  input  logic         burst_last,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] count,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         recovering
);
  localparam logic [W-1:0] ONE = W'(1);

  bwt_state_e state_q;
  bwt_state_e state_d;
  logic       waiting;
  logic       expired;
  logic       release_bus;

  assign waiting     = data_en & ~rdy_in;
  assign expired     = (limit != '0) & waiting & (count == (limit - ONE));
  assign release_bus = burst_last | ~data_en;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b1;
    cnt_inc = 1'b0;
    unique case (state_q)
      WATCH: begin
        cnt_clr = ~waiting;
        cnt_inc = waiting;
        if (expired) state_d = RECOVER;
      end
      RECOVER: begin
        if (release_bus) state_d = WATCH;
      end
      default: state_d = WATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WATCH;
    else        state_q <= state_d;
  end

  assign recovering = (state_q == RECOVER);
endmodule

// File: rtl/bus_watch_timer.sv
module bus_watch_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_en,
  input  logic             rdy_in,
  input  logic             burst_last,
  input  logic [CNT_W-1:0] limit,
  output logic             bus_err,
  output logic             force_rdy
);
  logic             rst_n_sync;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             recovering;
  logic [CNT_W-1:0] count;

  bwt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bwt_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count)
  );

  bwt_fsm #(.W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .data_en    (data_en),
    .rdy_in     (rdy_in),
    .burst_last (burst_last),
    .limit      (limit),
    .count      (count),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .recovering (recovering)
  );

  assign bus_err   = recovering;
  assign force_rdy = recovering;
endmodule

// File: rtl/bus_watch_timer_chk.sv
module bus_watch_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_en,
  input logic             rdy_in,
  input logic             burst_last,
  input logic [CNT_W-1:0] limit,
  input logic             bus_err,
  input logic             force_rdy
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // Independent count of consecutive unanswered edges seen outside recovery.
  logic [CNT_W-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else if (data_en && !rdy_in && !bus_err) begin
      if (wait_q != TOP) wait_q <= wait_q + CNT_W'(1);
    end
    else wait_q <= '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!bus_err && !force_rdy));

  // R2
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> (wait_q == limit));

  // R4
  idle_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_en && !bus_err) |=> !bus_err);

  // R5
  last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && data_en && burst_last) |=> !bus_err);

  // R6
  hold_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && data_en && !burst_last) |=> bus_err);

  // R7
  den_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !data_en) |=> !bus_err);

  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !bus_err) |=> !bus_err);

  // R10
  pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err == force_rdy);
endmodule

bind bus_watch_timer bus_watch_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_en    (data_en),
  .rdy_in     (rdy_in),
  .burst_last (burst_last),
  .limit      (limit),
  .bus_err    (bus_err),
  .force_rdy  (force_rdy)
);

// File: tb/bus_watch_timer_tb_top.sv
module bus_watch_timer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       data_en;
  logic       rdy_in;
  logic       burst_last;
  logic [7:0] limit;
  logic       bus_err;
  logic       force_rdy;

  int n_chk;
  int n_bad;

  bus_watch_timer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_en    (data_en),
    .rdy_in     (rdy_in),
    .burst_last (burst_last),
    .limit      (limit),
    .bus_err    (bus_err),
    .force_rdy  (force_rdy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, bus_err, exp);
    chk({req, "_R10"}, force_rdy, bus_err);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    data_en = 1'b0; rdy_in = 1'b0; burst_last = 1'b0;
    tick();
  endtask

  // Start a stalled beat and confirm it times out after exactly L edges.
  task automatic stall_to_timeout(input string req, input int lim);
    data_en = 1'b1; rdy_in = 1'b0; burst_last = 1'b0;
    for (int i = 1; i < lim; i++) tick();
    chk_out({req, "_before"}, 1'b0);
    tick();
    chk_out({req, "_at"}, 1'b1);
  endtask

  task automatic end_with_last(input string req);
    burst_last = 1'b1;
    chk_out({req, "_last_beat"}, 1'b1);
    tick();
    chk_out({req, "_after_last"}, 1'b0);
    go_idle();
  endtask

  task automatic t_reset();
    chk_out("R1", 1'b0);
  endtask

  task automatic t_timeout(input int lim);
    limit = 8'(lim);
    tick();
    stall_to_timeout("R2", lim);
    tick();
    chk_out("R5_hold", 1'b1);
    end_with_last("R5");
    stall_to_timeout("R8", lim);
    end_with_last("R8");
  endtask

  task automatic t_ready_clears(input int lim);
    limit = 8'(lim);
    tick();
    data_en = 1'b1; rdy_in = 1'b0;
    for (int i = 1; i < lim; i++) tick();
    rdy_in = 1'b1;
    tick();
    chk_out("R3_answered", 1'b0);
    stall_to_timeout("R3", lim);
    end_with_last("R3");
  endtask

  task automatic t_den_clears(input int lim);
    limit = 8'(lim);
    tick();
    data_en = 1'b1; rdy_in = 1'b0;
    for (int i = 1; i < lim; i++) tick();
    data_en = 1'b0;
    tick();
    chk_out("R4_gap", 1'b0);
    stall_to_timeout("R4", lim);
    end_with_last("R4");
  endtask

  task automatic t_ready_ignored(input int lim);
    limit = 8'(lim);
    tick();
    stall_to_timeout("R6_start", lim);
    rdy_in = 1'b1;
    tick();
    chk_out("R6", 1'b1);
    tick();
    chk_out("R6_again", 1'b1);
    rdy_in = 1'b0;
    end_with_last("R6");
  endtask

  task automatic t_den_drop(input int lim);
    limit = 8'(lim);
    tick();
    stall_to_timeout("R7_start", lim);
    data_en = 1'b0;
    tick();
    chk_out("R7", 1'b0);
    go_idle();
  endtask

  task automatic t_disabled();
    int seen = 0;
    limit = 8'd0;
    tick();
    data_en = 1'b1; rdy_in = 1'b0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (bus_err !== 1'b0 || force_rdy !== 1'b0) seen++;
    end
    n_chk++;
    if (seen != 0) begin
      n_bad++;
      $display("FAIL R9: actual=%0d error cycles expected=0", seen);
    end
    go_idle();
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b1; data_en = 1'b0; rdy_in = 1'b0; burst_last = 1'b0; limit = 8'd4;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_timeout(5);
    t_timeout(1);
    t_timeout(255);
    t_ready_clears(6);
    t_den_clears(3);
    t_ready_ignored(2);
    t_den_drop(4);
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule